// File: doc/BRIEF.md
# DDR Single-Burst Write Sequencer

This block performs one self-contained write to a DDR SDRAM that has already been initialized. A requester presents a flat address, a set of data words and a byte mask, and pulses a request while the block is idle. The block opens the addressed row, writes one burst with auto-precharge so the row closes by itself, and then hands the data and strobe pins back to the memory.

The flat address carries the bank in its top bits, the row in the middle and the column in the low bits. On the column command, address pin 10 is the auto-precharge flag, so any column bits at or above position 10 move up one pin. The memory-side outputs are per-cycle values for an external double-rate output stage: a rising-half and a falling-half data word, a strobe-pulse flag (strobe high for the first half-cycle and low for the second), and output enables for the data and strobe pads. The burst length is fixed by a parameter at 2 or 4 words. Each burst of two words takes one clock cycle.

Top module: `ddr_single_write`

## Requirements
- R1: The flat address splits into bank (top BANK_W bits), row (next ROW_W bits) and column (low COL_W bits). On the open-row cycle, memAddr carries the row zero-extended and memBank carries the bank. memBank keeps the same value on the column cycle.
- R2: Commands are coded {csN, rasN, casN, weN}: open-row 4'b0011, column write 4'b0100, no-op 4'b0111, deselect 4'b1111. After a request is accepted at a clock edge, the open-row command appears in the next cycle, a no-op follows, and then the column write.
- R3: On the column write, memAddr[10] is 1. Column bits below 10 appear on the same pins. Column bits from 10 upward appear one pin higher. Unused pins are 0.
- R4: In the column write cycle, both pad enables are on, the strobe is not pulsed (preamble low), and memDqm is all ones.
- R5: In each cycle after the column write, the strobe pulses, wrRise carries word 2p and wrFall carries word 2p+1 (word k is reqData[k*DATA_W +: DATA_W]), and memDqm carries the captured mask. There is one such cycle per pair of words: two cycles for burst length 4 and one for burst length 2.
- R6: After the last data cycle, both pad enables drop, two no-op cycles follow, and then done is high for exactly one cycle, with busy low in that cycle.
- R7: The data and strobe pad enables are high only from the column write cycle through the last data cycle, and never on any other cycle.
- R8: A request is accepted only while busy is low. Address, data and mask are captured at acceptance. Requests raised while busy, and later changes to the inputs, have no effect on the access in progress and start nothing.
- R9: When idle and out of reset, the block drives deselect, memDqm all ones, both pad enables low, no strobe pulse, and busy and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request a write; taken only while idle |
| reqAddr | input | BANK_W+ROW_W+COL_W | Flat address {bank,row,column} |
| reqData | input | BURST_LEN*DATA_W | Data words, word 0 in the low bits |
| reqMask | input | MASK_W | Byte mask applied to the burst |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse when the bus is released and idle |
| memCmd | output | 4 | {csN,rasN,casN,weN} |
| memBank | output | BANK_W | Bank select |
| memAddr | output | PIN_W | Row or column address pins |
| memDqm | output | MASK_W | Data mask pins |
| dqsOe | output | 1 | Strobe pad enable |
| dqsPulse | output | 1 | Strobe high-then-low this cycle |
| dqOe | output | 1 | Data pad enable |
| wrRise | output | DATA_W | Data for the first half-cycle |
| wrFall | output | DATA_W | Data for the second half-cycle |

## Verification
The assertions assume reset is held for at least two clock edges before the first request, so that the two-cycle history behind the bank-hold and command-order checks comes from idle cycles. They also assume the requester samples busy rather than tracking the sequence length itself. The stimulus raises requests only while idle, except in the deliberate overlap cases. In those cases it holds the request high during the access with scrambled inputs and drops it before the block can return to idle. This keeps every accepted access separated by at least one idle cycle, which is what the idle-state checks rely on.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_OPEN   = 4'b0011,
    CMD_WRITE  = 4'b0100,
    CMD_NOP    = 4'b0111,
    CMD_DESEL  = 4'b1111
  } memCmd_e;

  typedef enum logic [1:0] {
    ADDR_ZERO = 2'd0,
    ADDR_ROW  = 2'd1,
    ADDR_COL  = 2'd2
  } addrSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       capture;
    addrSel_e   addrSel;
    logic       busOe;
    logic       strobeOn;
    logic       maskOn;
    logic [1:0] beatSel;
  } dpCtl_t;

endpackage

// File: rtl/ddrw_ctrl.sv
module ddrw_ctrl
  import ddrw_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output dpCtl_t  ctl,
  output memCmd_e cmd,
  output logic    busy,
  output logic    done
);

  localparam int NPAIR = BURST_LEN / 2;
  localparam logic [1:0] LAST_PAIR = 2'(NPAIR - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_GAP, ST_WR, ST_BEAT, ST_TAIL
  } state_e;

  state_e     state, stateNext;
  logic [1:0] beatCnt;
  logic       tailCnt;
  logic       doneQ;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_OPEN;
      ST_OPEN: stateNext = ST_GAP;
      ST_GAP:  stateNext = ST_WR;
      ST_WR:   stateNext = ST_BEAT;
      ST_BEAT: if (beatCnt == LAST_PAIR) stateNext = ST_TAIL;
      ST_TAIL: if (tailCnt) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      tailCnt <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      beatCnt <= (state == ST_BEAT) ? beatCnt + 2'd1 : 2'd0;
      tailCnt <= (state == ST_TAIL) ? ~tailCnt : 1'b0;
      doneQ   <= (state == ST_TAIL) && tailCnt;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = (state == ST_IDLE) && reqValid;
    ctl.busOe    = (state == ST_WR) || (state == ST_BEAT);
    ctl.strobeOn = (state == ST_BEAT);
    ctl.maskOn   = (state == ST_BEAT);
    ctl.beatSel  = beatCnt;
    case (state)
      ST_OPEN: ctl.addrSel = ADDR_ROW;
      ST_WR:   ctl.addrSel = ADDR_COL;
      default: ctl.addrSel = ADDR_ZERO;
    endcase
    case (state)
      ST_IDLE: cmd = CMD_DESEL;
      ST_OPEN: cmd = CMD_OPEN;
      ST_WR:   cmd = CMD_WRITE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R2: open-row is followed by a no-op, then the column write
  a_r2_open_then_nop: assert property (@(posedge clk) disable iff (!rstN)
    cmd == CMD_OPEN |=> cmd == CMD_NOP);
  a_r2_write_order: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd, 2) == CMD_OPEN |-> cmd == CMD_WRITE);
  // R4: drivers turn on with a low preamble on the write cycle
  a_r4_preamble: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.busOe) |-> (cmd == CMD_WRITE) && !ctl.strobeOn);
  // R6: done is a single-cycle pulse with the block idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !ctl.busOe);
  // R7: strobe only pulses while pads are driven, pads only during an access
  a_r7_strobe_driven: assert property (@(posedge clk) disable iff (!rstN)
    ctl.strobeOn |-> ctl.busOe && busy);
  // R8: no new row opens while an access is in flight
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> cmd != CMD_OPEN);

endmodule

// File: rtl/ddrw_datapath.sv
module ddrw_datapath
  import ddrw_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 32,
  parameter int MASK_W    = 4,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  parameter int PIN_W     = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtl_t                        ctl,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [BURST_LEN*DATA_W-1:0]   reqData,
  input  logic [MASK_W-1:0]             reqMask,
  output logic [BANK_W-1:0]             memBank,
  output logic [PIN_W-1:0]              memAddr,
  output logic [MASK_W-1:0]             memDqm,
  output logic [DATA_W-1:0]             wrRise,
  output logic [DATA_W-1:0]             wrFall
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int NPAIR  = BURST_LEN / 2;

  logic [ADDR_W-1:0]           addrQ;
  logic [BURST_LEN*DATA_W-1:0] dataQ;
  logic [MASK_W-1:0]           maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (ctl.capture) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      maskQ <= reqMask;
    end
  end

  logic [BANK_W-1:0] bankF;
  logic [ROW_W-1:0]  rowF;
  logic [COL_W-1:0]  colF;
  logic [PIN_W-1:0]  rowPins, colPins;

  assign bankF   = addrQ[ADDR_W-1 -: BANK_W];
  assign rowF    = addrQ[COL_W +: ROW_W];
  assign colF    = addrQ[COL_W-1:0];
  assign rowPins = PIN_W'(rowF);

  // Column pins: low bits straight, flag at AP_BIT, upper bits shifted by one
  for (genvar i = 0; i < PIN_W; i++) begin : g_colPin
    if (i == AP_BIT) begin : g_flag
      assign colPins[i] = 1'b1;
    end else if (i < AP_BIT && i < COL_W) begin : g_low
      assign colPins[i] = colF[i];
    end else if (i > AP_BIT && i - 1 < COL_W) begin : g_high
      assign colPins[i] = colF[i-1];
    end else begin : g_pad
      assign colPins[i] = 1'b0;
    end
  end

  always_comb begin
    case (ctl.addrSel)
      ADDR_ROW: memAddr = rowPins;
      ADDR_COL: memAddr = colPins;
      default:  memAddr = '0;
    endcase
    memBank = (ctl.addrSel == ADDR_ZERO) ? '0 : bankF;
    memDqm  = ctl.maskOn ? maskQ : '1;
    wrRise  = '0;
    wrFall  = '0;
    if (ctl.strobeOn) begin
      for (int p = 0; p < NPAIR; p++) begin
        if (ctl.beatSel == 2'(p)) begin
          wrRise = dataQ[(2*p)*DATA_W +: DATA_W];
          wrFall = dataQ[(2*p+1)*DATA_W +: DATA_W];
        end
      end
    end
  end

  // R1: bank on the column cycle equals bank sent with the open-row cycle
  a_r1_bank_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrSel == ADDR_COL |-> memBank == $past(memBank, 2));
  // R8: captured request is frozen outside acceptance
  a_r8_capture_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(addrQ) && $stable(dataQ) && $stable(maskQ));

endmodule

// File: rtl/ddr_single_write.sv
module ddr_single_write
  import ddrw_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  localparam int MASK_W   = DATA_W / 8,
  localparam int COL_NEED = (COL_W >= AP_BIT) ? COL_W + 1 : AP_BIT + 1,
  localparam int PIN_W    = (ROW_W > COL_NEED) ? ROW_W : COL_NEED
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  input  logic [BURST_LEN*DATA_W-1:0]   reqData,
  input  logic [MASK_W-1:0]             reqMask,
  output logic                          busy,
  output logic                          done,
  output logic [3:0]                    memCmd,
  output logic [BANK_W-1:0]             memBank,
  output logic [PIN_W-1:0]              memAddr,
  output logic [MASK_W-1:0]             memDqm,
  output logic                          dqsOe,
  output logic                          dqsPulse,
  output logic                          dqOe,
  output logic [DATA_W-1:0]             wrRise,
  output logic [DATA_W-1:0]             wrFall
);

  dpCtl_t  ctl;
  memCmd_e cmd;

  ddrw_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .ctl(ctl), .cmd(cmd), .busy(busy), .done(done)
  );

  ddrw_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .MASK_W(MASK_W), .BURST_LEN(BURST_LEN), .AP_BIT(AP_BIT), .PIN_W(PIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask),
    .memBank(memBank), .memAddr(memAddr), .memDqm(memDqm),
    .wrRise(wrRise), .wrFall(wrFall)
  );

  assign memCmd   = cmd;
  assign dqOe     = ctl.busOe;
  assign dqsOe    = ctl.busOe;
  assign dqsPulse = ctl.strobeOn;

  // R3: column write always carries the auto-precharge flag
  a_r3_ap_flag: assert property (@(posedge clk) disable iff (!rstN)
    memCmd == 4'b0100 |-> memAddr[AP_BIT]);
  // R9: idle drives deselect with pads released
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> memCmd == 4'b1111 && !dqOe && !dqsOe && (&memDqm));

endmodule

// File: tb/ddr_single_write_tb.sv
module ddr_single_write_tb;

  localparam int ADDR_W = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [127:0]      reqData = '0;
  logic [3:0]        reqMask = '0;

  logic        busyA, doneA, dqsOeA, dqsPulseA, dqOeA;
  logic [3:0]  cmdA, dqmA;
  logic [1:0]  bankA;
  logic [12:0] addrA;
  logic [31:0] riseA, fallA;

  logic        busyB, doneB, dqsOeB, dqsPulseB, dqOeB;
  logic [3:0]  cmdB, dqmB;
  logic [1:0]  bankB;
  logic [11:0] addrB;
  logic [31:0] riseB, fallB;

  // burst 4, column 10 bits
  ddr_single_write #(.ROW_W(13), .COL_W(10), .BURST_LEN(4)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqMask(reqMask), .busy(busyA), .done(doneA),
    .memCmd(cmdA), .memBank(bankA), .memAddr(addrA), .memDqm(dqmA),
    .dqsOe(dqsOeA), .dqsPulse(dqsPulseA), .dqOe(dqOeA),
    .wrRise(riseA), .wrFall(fallA));

  // burst 2, column 11 bits (exercises the shift above the flag)
  ddr_single_write #(.ROW_W(12), .COL_W(11), .BURST_LEN(2)) u_dut2 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData[63:0]), .reqMask(reqMask), .busy(busyB), .done(doneB),
    .memCmd(cmdB), .memBank(bankB), .memAddr(addrB), .memDqm(dqmB),
    .dqsOe(dqsOeB), .dqsPulse(dqsPulseB), .dqOe(dqOeB),
    .wrRise(riseB), .wrFall(fallB));

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expCol(int colW, logic [ADDR_W-1:0] a);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < 10)       r[i] = (i < colW) ? a[i] : 1'b0;
      else if (i == 10) r[i] = 1'b1;
      else              r[i] = (i - 1 < colW) ? a[i-1] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [15:0] expRow(int colW, int rowW, logic [ADDR_W-1:0] a);
    return 16'((a >> colW) & ((32'd1 << rowW) - 1));
  endfunction

  // One cycle of one DUT, k cycles after the accepting edge
  task automatic chkCycle(string tag, int np, int colW, int rowW, int k,
                          logic [ADDR_W-1:0] a, logic [127:0] d, logic [3:0] m,
                          logic [3:0] cmd, logic [1:0] bank, logic [15:0] addr,
                          logic [3:0] dqm, logic dqsOe, logic pulse, logic dqOe,
                          logic [31:0] rise, logic [31:0] fall, logic busy, logic done);
    int doneK = 6 + np;
    bit drive = (k >= 3) && (k <= 3 + np);
    chk("R7", {tag, " dqOe"}, 128'(dqOe), 128'(drive));
    chk("R7", {tag, " dqsOe"}, 128'(dqsOe), 128'(drive));
    if (k == 1) begin
      chk("R2", {tag, " open cmd"}, 128'(cmd), 128'(4'b0011));
      chk("R1", {tag, " row pins"}, 128'(addr), 128'(expRow(colW, rowW, a)));
      chk("R1", {tag, " bank"}, 128'(bank), 128'(a[ADDR_W-1 -: 2]));
    end else if (k == 2) begin
      chk("R2", {tag, " gap cmd"}, 128'(cmd), 128'(4'b0111));
    end else if (k == 3) begin
      chk("R2", {tag, " write cmd"}, 128'(cmd), 128'(4'b0100));
      chk("R3", {tag, " col pins"}, 128'(addr), 128'(expCol(colW, a)));
      chk("R1", {tag, " bank on write"}, 128'(bank), 128'(a[ADDR_W-1 -: 2]));
      chk("R4", {tag, " preamble"}, 128'({pulse, dqm}), 128'({1'b0, 4'hF}));
    end else if (k <= 3 + np) begin
      int p = k - 4;
      chk("R5", {tag, " beat cmd/pulse"}, 128'({cmd, pulse}), 128'({4'b0111, 1'b1}));
      chk("R5", {tag, " rise word"}, 128'(rise), 128'(d[(2*p)*32 +: 32]));
      chk("R5", {tag, " fall word"}, 128'(fall), 128'(d[(2*p+1)*32 +: 32]));
      chk("R5", {tag, " mask"}, 128'(dqm), 128'(m));
    end else if (k < doneK) begin
      chk("R6", {tag, " tail"}, 128'({cmd, pulse, dqm, busy, done}),
          128'({4'b0111, 1'b0, 4'hF, 1'b1, 1'b0}));
    end else if (k == doneK) begin
      chk("R6", {tag, " done"}, 128'({cmd, busy, done}), 128'({4'b1111, 1'b0, 1'b1}));
    end else begin
      chk("R9", {tag, " idle after"}, 128'({cmd, pulse, dqm, busy, done}),
          128'({4'b1111, 1'b0, 4'hF, 1'b0, 1'b0}));
    end
    if (k < doneK) chk("R8", {tag, " busy"}, 128'(busy), 128'(1'b1));
  endtask

  task automatic runTxn(logic [ADDR_W-1:0] a, logic [127:0] d, logic [3:0] m, bit disturb);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqMask = m;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chkCycle("bl4", 2, 10, 13, k, a, d, m, cmdA, bankA, {3'b0, addrA}, dqmA,
               dqsOeA, dqsPulseA, dqOeA, riseA, fallA, busyA, doneA);
      chkCycle("bl2", 1, 11, 12, k, a, d, m, cmdB, bankB, {4'b0, addrB}, dqmB,
               dqsOeB, dqsPulseB, dqOeB, riseB, fallB, busyB, doneB);
      if (k == 1) reqValid = 1'b0;
      if (disturb && k == 2) begin
        // R8: scrambled request while busy
        reqValid = 1'b1;
        reqAddr  = ~a;
        reqData  = {$urandom, $urandom, $urandom, $urandom};
        reqMask  = ~m;
      end
      if (k == 5) reqValid = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "bl4 reset", 128'({cmdA, dqmA, dqOeA, dqsOeA, dqsPulseA, busyA, doneA}),
        128'({4'b1111, 4'hF, 5'b0}));
    chk("R9", "bl2 reset", 128'({cmdB, dqmB, dqOeB, dqsOeB, dqsPulseB, busyB, doneB}),
        128'({4'b1111, 4'hF, 5'b0}));
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "bl4 idle", 128'({cmdA, busyA}), 128'({4'b1111, 1'b0}));

    runTxn('0, '0, 4'h0, 1'b0);
    runTxn('1, {4{32'hFFFF_FFFF}}, 4'hF, 1'b0);
    runTxn(25'h1_5A5_5A5, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 4'h5, 1'b0);
    runTxn(25'h0_0007_FF, 128'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF, 4'hA, 1'b1);
    for (int t = 0; t < 24; t++) begin
      runTxn(ADDR_W'($urandom), {$urandom, $urandom, $urandom, $urandom},
             4'($urandom), (t % 4) == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule